// File: doc/BRIEF.md
# USB Bus Suspend Detector

This block watches the decoded full-speed line state and the start-of-frame strobe of a USB device. It decides when the device has to go into suspend, and when it has to come back out. A free-running millisecond tick paces a gap counter. Any start-of-frame or any bus state other than idle restarts that counter. When three ticks in a row pass with no such event, the block raises its suspend flag and latches a suspend-change interrupt bit.

The block leaves suspend in two ways: when traffic returns on the bus, or when an external agent pulls the suspend line low to reach the registers. A resume command from the local controller asks the transceiver to drive the K state for a programmable number of milliseconds. When that time is over, a second interrupt bit is latched. The interrupt line is active low and acts as a level: it stays asserted while any status bit is set. A read-acknowledge strobe clears the status bits. Control and status pins are plain levels and strobes, with no handshake.

Top module: `usb_suspend_detector`

## Requirements
- R1: Bus activity means `sof_pulse` high or `line_state` not equal to idle J (encoding 2'b00 SE0, 2'b01 J, 2'b10 K, 2'b11 SE1). Any activity restarts the count of silent milliseconds, including when it arrives in the same cycle as `ms_tick`.
- R2: After reset, `suspend_o` is 0, `drive_k` is 0, `int_status` is 2'b00 and `int_n` is 1.
- R3: In normal operation, the third consecutive `ms_tick` that arrives with no activity since the last restart sets `suspend_o` at that clock edge. The same edge sets `int_status[0]` (suspend change).
- R4: While suspended, any bus activity clears `suspend_o` at the next edge and sets `int_status[0]`.
- R5: While suspended, `wake_pull` high clears `suspend_o` at the next edge and sets `int_status[0]`.
- R6: In normal operation, `resume_cmd` raises `drive_k` from the next edge. `drive_k` stays high until the edge of the Nth `ms_tick`, then falls at that edge, and `int_status[1]` (resume done) is set at the same edge.
- R7: N is the value of `resume_len` sampled with the command, from 1 to 15. A value of 0 counts as 1. Changes to `resume_len` during the resume have no effect.
- R8: `int_ack` clears both status bits at the next edge. A bit that is set in the same cycle stays set.
- R9: `int_n` is low exactly while `int_status` is nonzero.
- R10: While suspended, `int_ack` and `resume_cmd` are ignored: the status bits and `drive_k` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_state | input | 2 | Decoded bus state: 00 SE0, 01 J, 10 K, 11 SE1 |
| sof_pulse | input | 1 | One-cycle strobe for each received start-of-frame |
| ms_tick | input | 1 | One-cycle strobe once per millisecond |
| wake_pull | input | 1 | External agent pulls the suspend line low |
| resume_cmd | input | 1 | Start remote-wake signalling |
| resume_len | input | 4 | Length of the K-state drive, in milliseconds |
| int_ack | input | 1 | Read-acknowledge, clears the status bits |
| suspend_o | output | 1 | Suspend flag (released high when suspended) |
| int_status | output | 2 | [0] suspend change, [1] resume done |
| int_n | output | 1 | Active-low level interrupt |
| drive_k | output | 1 | Request to drive the K state onto the bus |

## Verification
Two functions can fall in the same cycle. The first is the acknowledge clearing the status bits. The second is a new event setting one of them: either the third silent tick that enters suspend, or the final tick of a resume. The bench lines up `int_ack` with exactly that tick and then expects the affected bit, and `int_n` low, one cycle later. A start-of-frame placed on the third tick is a second collision: there, suspend must not be declared.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  typedef enum logic [1:0] {
    MD_RUN    = 2'b00,
    MD_SUSP   = 2'b01,
    MD_RESUME = 2'b10
  } mode_e;

  localparam int IRQ_CHG  = 0;
  localparam int IRQ_DONE = 1;
  localparam int NUM_IRQ  = 2;
endpackage

// File: rtl/usb_gap_timer.sv
module usb_gap_timer #(
  parameter int MISS_LIMIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic activity,
  input  logic tick,
  output logic expire
);
  localparam int CNT_W = $clog2(MISS_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MISS_LIMIT - 1);

  logic [CNT_W-1:0] gap_q;

  assign expire = armed && tick && !activity && (gap_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !armed || activity || expire) begin
      gap_q <= '0;
    end else if (tick) begin
      gap_q <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/usb_resume_timer.sv
module usb_resume_timer #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_in,
  input  logic             active,
  input  logic             tick,
  output logic             done
);
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt_q;

  assign done = active && tick && (cnt_q == len_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= LEN_W'(1);
      cnt_q <= '0;
    end else begin
      if (start) begin
        len_q <= (len_in == '0) ? LEN_W'(1) : len_in;
      end
      if (!active) begin
        cnt_q <= '0;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_irq_bank.sv
module usb_irq_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clear,
  output logic [N-1:0] status,
  output logic         irq_n
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        status[i] <= 1'b0;
      end else if (set[i]) begin
        status[i] <= 1'b1;
      end else if (clear) begin
        status[i] <= 1'b0;
      end
    end
  end

  assign irq_n = ~(|status);
endmodule

// File: rtl/usb_suspend_detector.sv
module usb_suspend_detector
  import usb_susp_pkg::*;
#(
  parameter int MISS_LIMIT = 3,
  parameter int LEN_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       line_state,
  input  logic             sof_pulse,
  input  logic             ms_tick,
  input  logic             wake_pull,
  input  logic             resume_cmd,
  input  logic [LEN_W-1:0] resume_len,
  input  logic             int_ack,
  output logic             suspend_o,
  output logic [1:0]       int_status,
  output logic             int_n,
  output logic             drive_k
);
  mode_e mode_q, mode_d;
  logic  activity, gap_expire, res_done, res_start;
  logic  in_run, in_susp, in_res, wake;
  logic [NUM_IRQ-1:0] irq_set;

  assign activity = sof_pulse || (line_state != LS_J);
  assign in_run   = (mode_q == MD_RUN);
  assign in_susp  = (mode_q == MD_SUSP);
  assign in_res   = (mode_q == MD_RESUME);
  assign wake     = in_susp && (activity || wake_pull);
  assign res_start = in_run && resume_cmd;

  usb_gap_timer #(.MISS_LIMIT(MISS_LIMIT)) u_gap (
    .clk(clk), .rst_n(rst_n), .armed(in_run), .activity(activity),
    .tick(ms_tick), .expire(gap_expire)
  );

  usb_resume_timer #(.LEN_W(LEN_W)) u_res (
    .clk(clk), .rst_n(rst_n), .start(res_start), .len_in(resume_len),
    .active(in_res), .tick(ms_tick), .done(res_done)
  );

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MD_RUN: begin
        if (resume_cmd)      mode_d = MD_RESUME;
        else if (gap_expire) mode_d = MD_SUSP;
      end
      MD_SUSP:   if (wake)     mode_d = MD_RUN;
      MD_RESUME: if (res_done) mode_d = MD_RUN;
      default:                 mode_d = MD_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MD_RUN;
    else        mode_q <= mode_d;
  end

  always_comb begin
    irq_set           = '0;
    irq_set[IRQ_CHG]  = (in_run && !resume_cmd && gap_expire) || wake;
    irq_set[IRQ_DONE] = res_done;
  end

  usb_irq_bank #(.N(NUM_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set), .clear(int_ack && !in_susp),
    .status(int_status), .irq_n(int_n)
  );

  assign suspend_o = in_susp;
  assign drive_k   = in_res;
endmodule

// File: rtl/usb_susp_chk.sv
module usb_susp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ms_tick,
  input logic       resume_cmd,
  input logic       suspend_o,
  input logic [1:0] int_status,
  input logic       int_n,
  input logic       drive_k
);
  // R3
  susp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_o |-> int_status[0]);
  // R3
  susp_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspend_o) |-> $past(ms_tick));
  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_o |-> !int_n);
  // R6
  resume_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_cmd && !suspend_o && !drive_k) |=> drive_k);
  // R6
  resume_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_k) |-> (int_status[1] && $past(ms_tick)));
  // R10
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_k && suspend_o));
endmodule

bind usb_suspend_detector usb_susp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .resume_cmd(resume_cmd),
  .suspend_o(suspend_o), .int_status(int_status), .int_n(int_n),
  .drive_k(drive_k)
);

// File: tb/usb_suspend_detector_bench.sv
module usb_suspend_detector_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] line_state = 2'b01;
  logic sof_pulse = 0, ms_tick = 0, wake_pull = 0, resume_cmd = 0, int_ack = 0;
  logic [3:0] resume_len = 4'd1;
  logic suspend_o, int_n, drive_k;
  logic [1:0] int_status;

  int checks = 0, failures = 0, cycles = 0;
  bit done_flag = 0;
  // reference model state: 0 run, 1 suspended, 2 resuming
  int m_mode = 0, m_gap = 0, m_rem = 0;
  bit m_s0 = 0, m_s1 = 0;

  usb_suspend_detector u_usb_suspend_detector (
    .clk(clk), .rst_n(rst_n), .line_state(line_state), .sof_pulse(sof_pulse),
    .ms_tick(ms_tick), .wake_pull(wake_pull), .resume_cmd(resume_cmd),
    .resume_len(resume_len), .int_ack(int_ack), .suspend_o(suspend_o),
    .int_status(int_status), .int_n(int_n), .drive_k(drive_k)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    bit act, set0, set1, clr;
    int old;
    act = sof_pulse || (line_state != 2'b01);
    set0 = 0; set1 = 0;
    old = m_mode;
    clr = int_ack && (old != 1);
    if (!rst_n) begin
      m_mode = 0; m_gap = 0; m_rem = 0; m_s0 = 0; m_s1 = 0;
    end else begin
      if (old == 0) begin
        if (resume_cmd) begin
          m_mode = 2; m_gap = 0; m_rem = (resume_len == 0) ? 1 : resume_len;
        end else if (act) m_gap = 0;
        else if (ms_tick) begin
          m_gap++;
          if (m_gap == 3) begin m_mode = 1; m_gap = 0; set0 = 1; end
        end
      end else if (old == 1) begin
        if (act || wake_pull) begin m_mode = 0; set0 = 1; end
      end else if (ms_tick) begin
        m_rem--;
        if (m_rem == 0) begin m_mode = 0; set1 = 1; end
      end
      m_s0 = set0 | (m_s0 & !clr);
      m_s1 = set1 | (m_s1 & !clr);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk(suspend_o == (m_mode == 1), "R3 suspend_o vs model", suspend_o, m_mode == 1);
      chk(drive_k == (m_mode == 2), "R6 drive_k vs model", drive_k, m_mode == 2);
      chk(int_status == {m_s1, m_s0}, "R8 int_status vs model", int_status, {m_s1, m_s0});
      chk(int_n == !(m_s1 | m_s0), "R9 int_n vs model", int_n, !(m_s1 | m_s0));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done_flag) begin
      done_flag = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic ms(input bit sof, input bit ack = 0);
    @(negedge clk); ms_tick = 1; sof_pulse = sof; int_ack = ack;
    @(negedge clk); ms_tick = 0; sof_pulse = 0; int_ack = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); int_ack = 1;
    @(negedge clk); int_ack = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(suspend_o == 0 && drive_k == 0 && int_status == 0 && int_n == 1,
        "R2 reset values", {suspend_o, drive_k, int_status, int_n}, 1);

    // SOFs every ms keep the device awake
    for (int i = 0; i < 6; i++) ms(1);
    chk(suspend_o == 0, "R1 SOF traffic keeps awake", suspend_o, 0);

    // three silent ms enter suspend
    ms(0); ms(0);
    chk(suspend_o == 0, "R3 two silent ticks not enough", suspend_o, 0);
    ms(0);
    chk(suspend_o == 1 && int_status[0] == 1, "R3 third silent tick suspends",
        {suspend_o, int_status[0]}, 3);
    chk(int_n == 0, "R9 irq level while pending", int_n, 0);

    // ack and resume command while suspended are ignored
    pulse_ack();
    @(negedge clk); resume_cmd = 1; @(negedge clk); resume_cmd = 0;
    @(negedge clk);
    chk(int_status[0] == 1 && drive_k == 0 && suspend_o == 1,
        "R10 ack/resume ignored in suspend", {int_status[0], drive_k, suspend_o}, 5);

    // host SOF wakes
    @(negedge clk); sof_pulse = 1; @(negedge clk); sof_pulse = 0;
    chk(suspend_o == 0 && int_status[0] == 1, "R4 SOF leaves suspend",
        {suspend_o, int_status[0]}, 1);
    pulse_ack();
    chk(int_status == 0 && int_n == 1, "R8 ack clears", int_status, 0);

    // K activity restarts the gap count
    ms(0); ms(0);
    @(negedge clk); line_state = 2'b10; @(negedge clk); line_state = 2'b01;
    ms(0); ms(0);
    chk(suspend_o == 0, "R1 K activity restarts count", suspend_o, 0);
    // SOF on the would-be third tick
    ms(1);
    chk(suspend_o == 0, "R1 SOF same cycle as tick", suspend_o, 0);
    ms(0); ms(0); ms(0);
    chk(suspend_o == 1, "R3 suspend after restart", suspend_o, 1);

    // wake pin
    @(negedge clk); wake_pull = 1; @(negedge clk); wake_pull = 0;
    chk(suspend_o == 0 && int_status[0] == 1, "R5 wake pull leaves suspend",
        {suspend_o, int_status[0]}, 1);
    pulse_ack();

    // resume for 2 ms, length changed mid-way
    @(negedge clk); resume_len = 4'd2; resume_cmd = 1;
    @(negedge clk); resume_cmd = 0; resume_len = 4'd9;
    chk(drive_k == 1, "R6 drive_k starts", drive_k, 1);
    ms(0);
    chk(drive_k == 1, "R7 still driving after 1 of 2", drive_k, 1);
    ms(0, 1); // ack collides with completion
    chk(drive_k == 0 && int_status[1] == 1, "R8 done set wins over ack",
        {drive_k, int_status[1]}, 1);
    chk(int_n == 0, "R9 irq after resume", int_n, 0);
    pulse_ack();

    // length 0 counts as 1
    @(negedge clk); resume_len = 4'd0; resume_cmd = 1;
    @(negedge clk); resume_cmd = 0;
    ms(0);
    chk(drive_k == 0 && int_status[1] == 1, "R7 zero length acts as one",
        {drive_k, int_status[1]}, 1);
    pulse_ack();

    // ack colliding with suspend entry
    ms(0); ms(0); ms(0, 1);
    chk(suspend_o == 1 && int_status[0] == 1, "R8 suspend set wins over ack",
        {suspend_o, int_status[0]}, 3);
    @(negedge clk); line_state = 2'b00; @(negedge clk); line_state = 2'b01;
    chk(suspend_o == 0, "R4 SE0 leaves suspend", suspend_o, 0);

    repeat (4) @(negedge clk);
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule